// File: doc/BRIEF.md
# UART Register Block with Watermark Interrupts

This block is the software-facing half of a UART. A 32-bit register bus reaches seven word registers: a transmit data port, a receive data port, two control words, an interrupt enable mask, a read-only interrupt pending word and a baud divisor. Bytes written to the transmit port wait in an eight-entry FIFO and leave on a valid/ready byte stream toward a serializer. Bytes from a deserializer arrive on a valid-only stream and wait in a second eight-entry FIFO until software reads them.

The bit shifting and the baud clock live elsewhere. The divisor is only held here and driven out to that logic. One level-sensitive interrupt line reports two watermark conditions. The transmit condition is that the transmit FIFO has drained below a programmed count. The receive condition is that the receive FIFO holds more than a programmed count. Each condition can be masked.

Read data is registered: `rd_valid` and `rd_data` appear one cycle after the access. Side effects take place at the clock edge that samples the access.

Top module: `uart_regs_wm`

## Requirements
- R1: An access takes effect only when all four byte enables are set. Any other access writes nothing, pops nothing, and its read returns 0.
- R2: After reset all control, mask and divisor registers read 0, both FIFOs are empty, `irq` is low and `tx_valid` is low.
- R3: A write to offset 0x00 pushes `bus_wdata[7:0]` into the transmit FIFO. When the FIFO already holds 8 bytes, the byte is dropped and the stored contents stay unchanged.
- R4: A read of offset 0x00 returns bit 31 set while the transmit FIFO holds 8 bytes, and 0 in every other bit. Bit 31 clears once an entry drains.
- R5: `tx_valid` is high only while the transmit FIFO is not empty and transmit enable (bit 0 of offset 0x08) is set. Bytes leave in write order. `tx_data` holds steady while `tx_valid` is high and `tx_ready` is low.
- R6: A byte on `rx_data` with `rx_valid` high is stored only when receive enable (bit 0 of offset 0x0C) is set and the receive FIFO holds fewer than 8 bytes. Otherwise it is discarded.
- R7: A read of offset 0x04 returns the oldest received byte in bits 7:0 with the other bits zero, and removes that byte. With the FIFO empty, the read returns 0x80000000 and changes nothing.
- R8: Offsets 0x08 and 0x0C keep bit 0 and a count field in bits 18:16. Offset 0x10 keeps bits 1:0. Offset 0x18 keeps DIV_W bits, which are also driven on `baud_div`. All other bits of these registers read 0.
- R9: Offset 0x14 reads bit 0 as (transmit level < transmit count) and bit 1 as (receive level > receive count). Writes to offset 0x14 have no effect.
- R10: `irq` is the OR of the pending bits ANDed with the enable bits, and it follows a mask write or a FIFO change from the next clock edge on.
- R11: Reads of offsets other than 0x00 to 0x18 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset |
| bus_be | input | 4 | Byte enables; only 4'hF is honoured |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Serializer takes the byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| irq | output | 1 | Watermark interrupt, level |
| baud_div | output | DIV_W | Stored divisor |

## Verification
Overflow on both sides is the hardest case to reach, because the transmit FIFO drains as soon as it is enabled. The stimulus first holds transmit enable low and writes nine bytes. Only then does it enable the stream with `tx_ready` high, so the scoreboard can show that the ninth byte never appears. On the receive side, nine bytes are pushed against a count of 2. Software then pops the FIFO one byte at a time, and the interrupt is checked to stay high after the fifth pop and fall after the sixth, where the level drops from 3 to 2.

// File: rtl/uart_regs_wm.sv
module uart_regs_wm #(
  parameter int DEPTH = 8,
  parameter int DIV_W = 32,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_req,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [3:0]       bus_be,
  input  logic [31:0]      bus_wdata,
  output logic             rd_valid,
  output logic [31:0]      rd_data,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  input  logic             tx_ready,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             irq,
  output logic [DIV_W-1:0] baud_div
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);
  localparam logic [AW-1:0] A_TXD = AW'(5'h00);
  localparam logic [AW-1:0] A_RXD = AW'(5'h04);
  localparam logic [AW-1:0] A_TXC = AW'(5'h08);
  localparam logic [AW-1:0] A_RXC = AW'(5'h0C);
  localparam logic [AW-1:0] A_IE  = AW'(5'h10);
  localparam logic [AW-1:0] A_IP  = AW'(5'h14);
  localparam logic [AW-1:0] A_DIV = AW'(5'h18);

  logic             tx_en, rx_en;
  logic [2:0]       tx_cnt, rx_cnt;
  logic [1:0]       ie;
  logic [DIV_W-1:0] div_q;

  logic [7:0]    tx_mem [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp;
  logic [LW-1:0] tx_lvl;
  logic [7:0]    rx_mem [DEPTH];
  logic [PW-1:0] rx_wp, rx_rp;
  logic [LW-1:0] rx_lvl;

  wire acc = bus_req && (bus_be == 4'hF);
  wire wr  = acc && bus_we;
  wire rd  = acc && !bus_we;

  wire tx_full = (tx_lvl == FULL_LVL);
  wire rx_full = (rx_lvl == FULL_LVL);
  wire rx_empty = (rx_lvl == '0);

  wire tx_push = wr && (bus_addr == A_TXD) && !tx_full;
  wire tx_pop  = tx_valid && tx_ready;
  wire rx_push = rx_valid && rx_en && !rx_full;
  wire rx_pop  = rd && (bus_addr == A_RXD) && !rx_empty;

  wire [1:0] ip = {rx_lvl > LW'(rx_cnt), tx_lvl < LW'(tx_cnt)};

  assign tx_valid = tx_en && (tx_lvl != '0);
  assign tx_data  = tx_mem[tx_rp];
  assign irq      = |(ip & ie);
  assign baud_div = div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en  <= 1'b0;
      rx_en  <= 1'b0;
      tx_cnt <= '0;
      rx_cnt <= '0;
      ie     <= '0;
      div_q  <= '0;
    end else if (wr) begin
      case (bus_addr)
        A_TXC: begin tx_en <= bus_wdata[0]; tx_cnt <= bus_wdata[18:16]; end
        A_RXC: begin rx_en <= bus_wdata[0]; rx_cnt <= bus_wdata[18:16]; end
        A_IE:  ie    <= bus_wdata[1:0];
        A_DIV: div_q <= bus_wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[7:0];
    if (rx_push) rx_mem[rx_wp] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_lvl <= '0;
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_lvl <= '0;
    end else begin
      if (tx_push) tx_wp <= (tx_wp == LAST_PTR) ? '0 : tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= (tx_rp == LAST_PTR) ? '0 : tx_rp + 1'b1;
      tx_lvl <= tx_lvl + LW'(tx_push) - LW'(tx_pop);
      if (rx_push) rx_wp <= (rx_wp == LAST_PTR) ? '0 : rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= (rx_rp == LAST_PTR) ? '0 : rx_rp + 1'b1;
      rx_lvl <= rx_lvl + LW'(rx_push) - LW'(rx_pop);
    end
  end

  logic [31:0] rmux;
  always_comb begin
    rmux = '0;
    if (rd) begin
      case (bus_addr)
        A_TXD: rmux = {tx_full, 31'b0};
        A_RXD: rmux = rx_empty ? 32'h8000_0000 : {24'b0, rx_mem[rx_rp]};
        A_TXC: rmux = {13'b0, tx_cnt, 15'b0, tx_en};
        A_RXC: rmux = {13'b0, rx_cnt, 15'b0, rx_en};
        A_IE:  rmux = {30'b0, ie};
        A_IP:  rmux = {30'b0, ip};
        A_DIV: rmux = 32'(div_q);
        default: rmux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_req && !bus_we;
      rd_data  <= rmux;
    end
  end
endmodule

// File: rtl/uart_regs_wm_chk.sv
module uart_regs_wm_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 5,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [3:0]    bus_be,
  input logic          rd_valid,
  input logic [31:0]   rd_data,
  input logic          tx_valid,
  input logic [7:0]    tx_data,
  input logic          tx_ready,
  input logic          tx_en,
  input logic [LW-1:0] tx_lvl,
  input logic          rx_valid,
  input logic [LW-1:0] rx_lvl
);
  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  assert_tx_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_valid);

  assert_rx_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lvl <= LW'(DEPTH));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lvl == LW'(DEPTH) && rx_valid && !(bus_req && !bus_we) |=> rx_lvl == LW'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lvl == LW'(DEPTH) && !tx_valid |=> tx_lvl == LW'(DEPTH));

  assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we && bus_be == 4'hF && bus_addr == AW'(5'h04) && rx_lvl == '0
    |=> rd_valid && rd_data == 32'h8000_0000);
endmodule

bind uart_regs_wm uart_regs_wm_chk #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_be(bus_be), .rd_valid(rd_valid), .rd_data(rd_data),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .tx_en(tx_en),
  .tx_lvl(tx_lvl), .rx_valid(rx_valid), .rx_lvl(rx_lvl)
);

// File: tb/tb_uart_regs_wm.sv
module tb_uart_regs_wm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic tx_valid, tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic irq;
  logic [31:0] baud_div;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic [7:0] tx_q[$];

  always #4 clk = ~clk;

  uart_regs_wm dut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(logic we, logic [4:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    acc(1'b1, a, d, 4'hF);
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    acc(1'b0, a, 32'h0, 4'hF);
  endtask

  task automatic rx_byte(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("read-extra", rd_data, 32'hxxxx_xxxx);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
    if (rst_n && tx_valid && tx_ready) begin
      if (tx_q.size() == 0) check("R3 unexpected tx byte", {24'b0, tx_data}, 32'hffff_ffff);
      else check("R5 tx order", {24'b0, tx_data}, {24'b0, tx_q.pop_front()});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 irq", {31'b0, irq}, 32'h0);
    check("R2 tx_valid", {31'b0, tx_valid}, 32'h0);
    check("R2 baud_div", baud_div, 32'h0);
    rd(5'h08, 32'h0, "R2 txctrl");
    rd(5'h0C, 32'h0, "R2 rxctrl");
    rd(5'h10, 32'h0, "R2 ie");
    rd(5'h14, 32'h0, "R2 ip");
    rd(5'h18, 32'h0, "R2 div");
    rd(5'h04, 32'h8000_0000, "R7 empty rx");
    rd(5'h00, 32'h0, "R4 tx not full");

    wr(5'h18, 32'h0000_1234);
    rd(5'h18, 32'h0000_1234, "R8 div");
    check("R8 baud_div", baud_div, 32'h0000_1234);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, 32'h0007_0001, "R8 txctrl fields");
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'hFFFF_FFFE);
    rd(5'h0C, 32'h0007_0000, "R8 rxctrl fields");
    wr(5'h0C, 32'h0);
    wr(5'h10, 32'hFFFF_FFFC);
    rd(5'h10, 32'h0, "R8 ie fields");
    rd(5'h1C, 32'h0, "R11 unmapped");
    wr(5'h14, 32'h3);
    rd(5'h14, 32'h0, "R9 ip read-only");
    acc(1'b1, 5'h18, 32'h55, 4'b0011);
    rd(5'h18, 32'h0000_1234, "R1 partial write ignored");

    for (int i = 0; i < 9; i++) begin
      wr(5'h00, 32'hAB00 | (32'h10 + i));
      if (i < 8) tx_q.push_back(8'(8'h10 + i));
    end
    check("R5 tx gated", {31'b0, tx_valid}, 32'h0);
    rd(5'h00, 32'h8000_0000, "R4 tx full flag");
    tx_ready = 1'b1;
    wr(5'h08, 32'h0005_0001);
    repeat (12) @(negedge clk);
    check("R3 tx drained", tx_q.size(), 0);
    rd(5'h00, 32'h0, "R4 full flag clears");
    rd(5'h14, 32'h1, "R9 tx watermark");
    check("R10 masked", {31'b0, irq}, 32'h0);
    wr(5'h10, 32'h1);
    check("R10 tx irq", {31'b0, irq}, 32'h1);
    wr(5'h10, 32'h0);
    check("R10 irq masked again", {31'b0, irq}, 32'h0);
    wr(5'h08, 32'h0);

    rx_byte(8'hAA);
    rd(5'h04, 32'h8000_0000, "R6 rx disabled drop");
    wr(5'h0C, 32'h0002_0001);
    for (int i = 0; i < 9; i++) rx_byte(8'(8'h20 + i));
    rd(5'h14, 32'h2, "R9 rx watermark");
    wr(5'h10, 32'h2);
    check("R10 rx irq", {31'b0, irq}, 32'h1);
    exp_q.push_back(32'h0);
    tag_q.push_back("R1 partial read");
    acc(1'b0, 5'h04, 32'h0, 4'b0001);
    for (int i = 0; i < 8; i++) begin
      rd(5'h04, 32'h20 + i, "R7 rx pop order");
      if (i == 4) check("R10 irq level 3", {31'b0, irq}, 32'h1);
      if (i == 5) check("R10 irq level 2", {31'b0, irq}, 32'h0);
    end
    rd(5'h04, 32'h8000_0000, "R6 ninth rx byte dropped");

    repeat (3) @(negedge clk);
    check("R7 scoreboard empty", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule